// File: doc/BRIEF.md
# EEPROM Page-Latch Access Controller

This block is the register-side front end of a small byte-wide non-volatile array of 32 pages with 4 bytes each. The array is held in a register-array model. A CPU reaches it through three registers on a simple register bus: an address pointer, a data window and a cycle-control register. A read of the data window returns the array byte under the pointer. A write to the data window does not touch the array. It sets bits in one of four page latches.

A page is programmed in two steps. Software first stages up to four bytes in the latches. It then starts either an erase cycle, which clears the page, or a write cycle, which merges the latch contents into the page by bitwise OR. The pointer steps in a fixed way. It moves forward after data-window reads and after write cycles, and it stays put after erase cycles. A staging mode can advance only its two low bits after each latch write, and that sub-pointer stops at the last latch. All latches go back to zero when any cycle ends.

Top module: `pglatch_eeprom_ctrl`

## Requirements
- R1: After synchronous active-low reset, the pointer is 0, `cycle_busy` is 0, increment mode is off, every latch is 0 and every array byte reads 0x00.
- R2: Writing register 0 (pointer) stores write-data bits 6..0. Reading register 0 returns the pointer with bit 7 always 0.
- R3: Reading register 1 (data window) returns the array byte at pointer bits 6..0. The pointer then advances by one, and 127 wraps to 0.
- R4: Writing register 1 sets bits in latch number pointer[1:0]. When increment mode is on, pointer[1:0] then advances by one unless it already equals 3, and pointer[6:2] never changes. When increment mode is off, the pointer is unchanged.
- R5: Latch bits can only be set. Repeated writes to the same latch accumulate as a bitwise OR.
- R6: Writing register 2 with bit 0 set starts an erase cycle. Writing it with bit 1 set and bit 0 clear starts a write cycle, so erase wins when both bits are set. `cycle_busy` is high for exactly CYCLE_CLKS clocks, beginning the clock after the start.
- R7: A start request made while `cycle_busy` is high is ignored, and the running cycle is not altered.
- R8: An erase cycle sets all four bytes of the page pointer[6:2] (captured at start) to 0x00. Pointer bits 1..0 have no effect on it, and the pointer is unchanged afterwards.
- R9: A write cycle ORs latch k into byte k of the captured page. The pointer advances by one at the end of the cycle, and 127 wraps to 0.
- R10: All latches are cleared at the end of every cycle, so a following write cycle with no latch writes leaves the page unchanged.
- R11: Register 2 reads bit 2 = increment mode (written from write-data bit 2 on every register-2 write) and bit 3 = busy, with other bits 0. Register 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (data-window reads advance the pointer) |
| bus_reg | input | 2 | Register select: 0 pointer, 1 data window, 2 control, 3 reserved |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the selected register, combinational |
| cycle_busy | output | 1 | Erase or write cycle in progress |

## Verification
The embedded assertions watch several things on every clock: the pointer's stepping rules (full step on reads, sub-pointer saturation at the last latch, page bits untouched by staging, hold when nothing steps), the set-only behaviour of the latches and their clearing at cycle end, the rejection of new starts while busy, and the zeroed page after an erase. What data ends up in a page after staged writes, the exact busy length, the erase-over-write priority, and wrap-around after a write cycle at the top address can only be shown by the bench scenarios. Those scenarios are compared against a behavioural model on every clock.

// File: rtl/pgl_pkg.sv
// Shared definitions for the page-latch EEPROM controller.
// Assumes a 2-bit register select on the CPU bus.
package pgl_pkg;
    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        CYC_ERASE = 1'b0,
        CYC_WRITE = 1'b1
    } cyc_kind_e;

    localparam int CTL_ERASE_BIT = 0;
    localparam int CTL_WRITE_BIT = 1;
    localparam int CTL_INC_BIT   = 2;
    localparam int CTL_BUSY_BIT  = 3;
endpackage

// File: rtl/pgl_addr_ctr.sv
// Address pointer: loadable counter with a full step and a saturating
// sub-pointer step on its low SW bits. Priority: load, full step, sub step.
// Assumes AW > SW.
module pgl_addr_ctr #(
    parameter int AW = 7,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step_full,
    input  logic          step_sub,
    output logic [AW-1:0] addr
);
    localparam logic [SW-1:0] SUB_LAST = '1;

    logic [AW-1:0] addr_q;

    // Update the pointer according to the step priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (step_full) begin
            addr_q <= addr_q + 1'b1;
        end else if (step_sub && addr_q[SW-1:0] != SUB_LAST) begin
            addr_q <= {addr_q[AW-1:SW], addr_q[SW-1:0] + 1'b1};
        end
    end

    assign addr = addr_q;

    p_read_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_full && !load) |=> addr_q == AW'($past(addr_q) + 1'b1));

    p_sub_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_sub && !step_full && !load && addr_q[SW-1:0] == SUB_LAST) |=> $stable(addr_q));

    p_sub_keeps_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_sub && !step_full && !load) |=> addr_q[AW-1:SW] == $past(addr_q[AW-1:SW]));

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_sub && !step_full && !load) |=> $stable(addr_q));
endmodule

// File: rtl/pgl_latch_bank.sv
// Page latches: NLAT set-only byte latches. A write ORs data into the
// selected latch; a clear empties all of them and wins over a write.
module pgl_latch_bank #(
    parameter int NLAT = 4,
    parameter int DW   = 8,
    localparam int SW  = $clog2(NLAT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [SW-1:0]             sel,
    input  logic [DW-1:0]             wdata,
    input  logic                      clr,
    output logic [NLAT-1:0][DW-1:0]   lat
);
    logic [NLAT-1:0][DW-1:0] lat_q;

    for (genvar g = 0; g < NLAT; g++) begin : g_lat
        // Set bits of latch g, or empty it at the end of a cycle.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                lat_q[g] <= '0;
            end else if (wr && sel == SW'(g)) begin
                lat_q[g] <= lat_q[g] | wdata;
            end
        end
    end

    assign lat = lat_q;

    p_set_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> (lat_q[$past(sel)] & $past(wdata)) == $past(wdata));

    p_clear_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> lat_q == '0);
endmodule

// File: rtl/pgl_cycle_seq.sv
// Cycle sequencer: accepts an erase or write start when idle, captures the
// target page, holds busy for CYCLE_CLKS clocks and pulses done in the last.
module pgl_cycle_seq #(
    parameter int CYCLE_CLKS = 20,
    parameter int PW         = 5,
    localparam int CW        = $clog2(CYCLE_CLKS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_erase,
    input  logic                  start_write,
    input  logic [PW-1:0]         page_in,
    output logic                  busy,
    output logic                  done,
    output pgl_pkg::cyc_kind_e    kind,
    output logic [PW-1:0]         page
);
    import pgl_pkg::*;

    localparam logic [CW-1:0] LAST = CW'(CYCLE_CLKS - 1);

    logic               busy_q;
    logic [CW-1:0]      cnt_q;
    cyc_kind_e          kind_q;
    logic [PW-1:0]      page_q;
    logic               start;

    assign start = start_erase || start_write;
    assign done  = busy_q && cnt_q == '0;

    // Run the cycle timer and capture the request at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            kind_q <= CYC_ERASE;
            page_q <= '0;
        end else if (done) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= LAST;
            kind_q <= start_erase ? CYC_ERASE : CYC_WRITE;
            page_q <= page_in;
        end
    end

    assign busy = busy_q;
    assign kind = kind_q;
    assign page = page_q;

    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start && !done) |=> busy_q && $stable(kind_q) && $stable(page_q));

    p_done_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy_q);
endmodule

// File: rtl/pgl_store.sv
// Behavioural array of PAGES x NLAT bytes. On commit, the captured page is
// cleared (erase) or ORed with the latches (write). Assumes power-of-two sizes.
module pgl_store #(
    parameter int PAGES = 32,
    parameter int NLAT  = 4,
    parameter int DW    = 8,
    localparam int SW   = $clog2(NLAT),
    localparam int PW   = $clog2(PAGES),
    localparam int AW   = PW + SW,
    localparam int DEPTH = PAGES * NLAT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            rd_addr,
    output logic [DW-1:0]            rdata,
    input  logic                     commit,
    input  pgl_pkg::cyc_kind_e       kind,
    input  logic [PW-1:0]            page,
    input  logic [NLAT-1:0][DW-1:0]  lat
);
    import pgl_pkg::*;

    logic [DW-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        // Apply a committed cycle to byte g when its page is the target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (commit && page == PW'(g / NLAT)) begin
                mem_q[g] <= (kind == CYC_ERASE) ? '0 : (mem_q[g] | lat[g % NLAT]);
            end
        end
    end

    assign rdata = mem_q[rd_addr];

    p_erase_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && kind == CYC_ERASE) |=> mem_q[{$past(page), {SW{1'b0}}}] == '0);
endmodule

// File: rtl/pglatch_eeprom_ctrl.sv
// Top: decodes the register bus, keeps increment mode, steers pointer
// stepping and ties latches, sequencer and array together.
// Assumes one access per cycle (read and write strobes not both set).
module pglatch_eeprom_ctrl #(
    parameter int PAGES      = 32,
    parameter int PAGE_BYTES = 4,
    parameter int DW         = 8,
    parameter int CYCLE_CLKS = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_reg,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          cycle_busy
);
    import pgl_pkg::*;

    localparam int NLAT = PAGE_BYTES;
    localparam int SW   = $clog2(PAGE_BYTES);
    localparam int PW   = $clog2(PAGES);
    localparam int AW   = PW + SW;

    logic                    wr_addr, wr_data, wr_ctrl, rd_data;
    logic                    inc_q;
    logic [AW-1:0]           addr;
    logic                    busy, done;
    cyc_kind_e               kind;
    logic [PW-1:0]           cyc_page;
    logic [NLAT-1:0][DW-1:0] lat;
    logic [DW-1:0]           store_rd;
    logic                    start_erase, start_write;

    // Decode bus strobes per register.
    always_comb begin
        wr_addr = bus_sel && bus_wr && reg_sel_e'(bus_reg) == SEL_ADDR;
        wr_data = bus_sel && bus_wr && reg_sel_e'(bus_reg) == SEL_DATA;
        wr_ctrl = bus_sel && bus_wr && reg_sel_e'(bus_reg) == SEL_CTRL;
        rd_data = bus_sel && bus_rd && reg_sel_e'(bus_reg) == SEL_DATA;
    end

    assign start_erase = wr_ctrl && bus_wdata[CTL_ERASE_BIT];
    assign start_write = wr_ctrl && bus_wdata[CTL_WRITE_BIT] && !bus_wdata[CTL_ERASE_BIT];

    // Hold increment mode from every control-register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_q <= 1'b0;
        end else if (wr_ctrl) begin
            inc_q <= bus_wdata[CTL_INC_BIT];
        end
    end

    pgl_addr_ctr #(.AW(AW), .SW(SW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_addr),
        .load_val  (bus_wdata[AW-1:0]),
        .step_full (rd_data || (done && kind == CYC_WRITE)),
        .step_sub  (wr_data && inc_q),
        .addr      (addr)
    );

    pgl_latch_bank #(.NLAT(NLAT), .DW(DW)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_data),
        .sel   (addr[SW-1:0]),
        .wdata (bus_wdata),
        .clr   (done),
        .lat   (lat)
    );

    pgl_cycle_seq #(.CYCLE_CLKS(CYCLE_CLKS), .PW(PW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_erase (start_erase),
        .start_write (start_write),
        .page_in     (addr[AW-1:SW]),
        .busy        (busy),
        .done        (done),
        .kind        (kind),
        .page        (cyc_page)
    );

    pgl_store #(.PAGES(PAGES), .NLAT(NLAT), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (addr),
        .rdata   (store_rd),
        .commit  (done),
        .kind    (kind),
        .page    (cyc_page),
        .lat     (lat)
    );

    // Return the selected register's value.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            unique case (reg_sel_e'(bus_reg))
                SEL_ADDR: bus_rdata = DW'(addr);
                SEL_DATA: bus_rdata = store_rd;
                SEL_CTRL: begin
                    bus_rdata[CTL_INC_BIT]  = inc_q;
                    bus_rdata[CTL_BUSY_BIT] = busy;
                end
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign cycle_busy = busy;

    p_erase_keeps_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind == CYC_ERASE && !wr_addr && !rd_data && !wr_data) |=> $stable(addr));
endmodule

// File: tb/pglatch_eeprom_ctrl_test.sv
// Bench: behavioural model compared every clock plus directed scenarios.
module pglatch_eeprom_ctrl_test;
    localparam int N = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_reg = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       cycle_busy;

    int compared = 0;
    int mismatched = 0;

    int m_addr, m_busy, m_cnt, m_kind, m_page, m_inc;
    int m_lat[4];
    int m_mem[128];

    always #4 clk = ~clk;

    pglatch_eeprom_ctrl #(.CYCLE_CLKS(N)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_reg(bus_reg), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cycle_busy(cycle_busy)
    );

    task automatic check(input int got, input int exp, input string tag);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = 0; m_busy = 0; m_cnt = 0; m_kind = 0; m_page = 0; m_inc = 0;
            foreach (m_lat[i]) m_lat[i] = 0;
            foreach (m_mem[i]) m_mem[i] = 0;
        end else begin
            bit done, wa, wd, wc, rdd;
            int na;
            done = (m_busy != 0) && (m_cnt == 0);
            wa = bus_sel && bus_wr && bus_reg == 2'd0;
            wd = bus_sel && bus_wr && bus_reg == 2'd1;
            wc = bus_sel && bus_wr && bus_reg == 2'd2;
            rdd = bus_sel && bus_rd && bus_reg == 2'd1;
            na = m_addr;
            if (wa) na = bus_wdata & 127;
            else if (rdd || (done && m_kind == 1)) na = (m_addr + 1) % 128;
            else if (wd && m_inc != 0 && (m_addr % 4) != 3) na = m_addr + 1;
            if (done) begin
                for (int k = 0; k < 4; k++) begin
                    if (m_kind == 0) m_mem[m_page*4+k] = 0;
                    else m_mem[m_page*4+k] = m_mem[m_page*4+k] | m_lat[k];
                    m_lat[k] = 0;
                end
            end else if (wd) begin
                m_lat[m_addr % 4] = m_lat[m_addr % 4] | int'(bus_wdata);
            end
            if (done) m_busy = 0;
            else if (m_busy != 0) m_cnt--;
            else if (wc && (bus_wdata[0] || bus_wdata[1])) begin
                m_busy = 1; m_cnt = N - 1; m_kind = bus_wdata[0] ? 0 : 1; m_page = m_addr / 4;
            end
            if (wc) m_inc = bus_wdata[2];
            m_addr = na;
        end
    end

    // Compare outputs with the model between edges.
    always @(negedge clk) begin
        #3;
        if (rst_n) begin
            int exp;
            check(cycle_busy, m_busy, "R6 busy");
            if (bus_sel && !bus_wr) begin
                case (bus_reg)
                    2'd0: exp = m_addr;
                    2'd1: exp = m_mem[m_addr];
                    2'd2: exp = (m_inc << 2) | (m_busy << 3);
                    default: exp = 0;
                endcase
                check(bus_rdata, exp, "R11 model readback");
            end
        end
    end

    task automatic bus_write(input logic [1:0] r, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_rd = 1'b0; bus_reg = r; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic check_read(input logic [1:0] r, input int exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_wr = 1'b0; bus_reg = r;
        #3;
        check(bus_rdata, exp, tag);
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        #3;
        while (cycle_busy) begin
            n++;
            @(negedge clk);
            #3;
        end
    endtask

    initial begin
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #3 check(cycle_busy, 0, "R1 busy");
        check_read(2'd0, 8'h00, "R1 pointer");
        check_read(2'd2, 8'h00, "R1 control");
        check_read(2'd1, 8'h00, "R1 array byte");
        // R2 bit 7 dropped; R3 wrap on read
        bus_write(2'd0, 8'hFF);
        check_read(2'd0, 8'h7F, "R2 pointer bit7");
        check_read(2'd1, 8'h00, "R3 read top");
        check_read(2'd0, 8'h00, "R3 wrap");
        // R4 staging with increment and saturation
        bus_write(2'd2, 8'h04);
        bus_write(2'd0, 8'h08);
        bus_write(2'd1, 8'h11);
        bus_write(2'd1, 8'h22);
        bus_write(2'd1, 8'h33);
        bus_write(2'd1, 8'h44);
        bus_write(2'd1, 8'h80);
        check_read(2'd0, 8'h0B, "R4 sub saturate");
        // R9 write cycle, R7 ignored start, R11 busy flag
        bus_write(2'd2, 8'h06);
        check_read(2'd2, 8'h0C, "R11 busy bit");
        bus_write(2'd2, 8'h05);
        wait_idle(n);
        check_read(2'd0, 8'h0C, "R9 pointer step");
        check_read(2'd2, 8'h04, "R11 idle control");
        bus_write(2'd0, 8'h08);
        check_read(2'd1, 8'h11, "R7 write not erase");
        check_read(2'd1, 8'h22, "R9 byte1");
        check_read(2'd1, 8'h33, "R9 byte2");
        check_read(2'd1, 8'hC4, "R9 byte3");
        // R5 OR into one latch, R4 no increment, R6 length
        bus_write(2'd2, 8'h00);
        bus_write(2'd0, 8'h08);
        bus_write(2'd1, 8'h01);
        bus_write(2'd1, 8'h02);
        check_read(2'd0, 8'h08, "R4 no increment");
        bus_write(2'd2, 8'h02);
        wait_idle(n);
        check(n, N, "R6 busy length");
        bus_write(2'd0, 8'h08);
        check_read(2'd1, 8'h13, "R5 latch OR");
        // R10 latches cleared: empty write cycle changes nothing
        bus_write(2'd0, 8'h08);
        bus_write(2'd2, 8'h02);
        wait_idle(n);
        bus_write(2'd0, 8'h08);
        check_read(2'd1, 8'h13, "R10 byte0");
        check_read(2'd1, 8'h22, "R10 byte1");
        check_read(2'd1, 8'h33, "R10 byte2");
        check_read(2'd1, 8'hC4, "R10 byte3");
        // R8 erase with nonzero low bits
        bus_write(2'd0, 8'h0A);
        bus_write(2'd2, 8'h01);
        wait_idle(n);
        check_read(2'd0, 8'h0A, "R8 pointer held");
        bus_write(2'd0, 8'h08);
        for (int k = 0; k < 4; k++) check_read(2'd1, 8'h00, "R8 page zero");
        // R9 wrap after write cycle at top address
        bus_write(2'd0, 8'h7F);
        bus_write(2'd1, 8'h5A);
        bus_write(2'd2, 8'h02);
        wait_idle(n);
        check_read(2'd0, 8'h00, "R9 wrap");
        bus_write(2'd0, 8'h7F);
        check_read(2'd1, 8'h5A, "R9 top byte");
        check_read(2'd0, 8'h00, "R3 wrap again");
        // R11 reserved register
        check_read(2'd3, 8'h00, "R11 reserved");
        // R6 erase wins over write
        bus_write(2'd0, 8'h7C);
        bus_write(2'd2, 8'h03);
        wait_idle(n);
        check_read(2'd0, 8'h7C, "R6 erase priority pointer");
        bus_write(2'd0, 8'h7F);
        check_read(2'd1, 8'h00, "R6 erase priority data");
        repeat (2) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule